// File: doc/BRIEF.md
# Local Bus Interrupt Controller

This block gathers sixteen level-sensitive interrupt requests from devices on a local peripheral bus and folds them into a single request line toward the processor. Each request passes through a two-flop synchroniser and lands in a source register that simply tracks the line level. A software-owned enable mask selects which sources may raise the output. The AND of source and mask forms the pending set, and the output is high whenever that set is non-empty.

Software uses a small 16-bit register port with two locations. The first is a read-only vector register. It names the lowest-numbered pending line i by returning (i+1)<<2, or zero when nothing is pending, so the value can index a handler table directly. The second holds the enable mask and can be read and written. Read and write have separate address inputs, so one cycle can carry both.

Top module: `lbic_top`

## Requirements
- R1: On reset the enable mask is 0x0010, the source register is 0, `irq_out` is low and `rd_data` is 0; with that mask, line 4 alone can raise the output.
- R2: A level change on `irq_lines[i]` reaches the source register after two rising edges, so `irq_out` follows it after the second edge and not after the first.
- R3: `irq_out` is high exactly when at least one bit of (source AND mask) is set.
- R4: A read with `rd_addr` = 0x000 returns, on `rd_data` after the next rising edge, (i+1)<<2 for the lowest-numbered pending line i.
- R5: The vector read returns 0 when no line is pending, including when sources are high but masked off.
- R6: A write with `wr_addr` = 0x002 replaces the mask with `wr_data`, and `irq_out` reflects the new mask right after that edge. A read at 0x002 returns the mask.
- R7: A write to any offset other than 0x002 leaves the mask and `irq_out` unchanged. A read at any offset other than 0x000 or 0x002 returns 0.
- R8: When a mask write and a read fall in the same cycle, the read returns the value from before the write.
- R9: The source register cannot be written: a write at 0x000 changes neither the vector read nor `irq_out`.
- R10: `rd_data` is 0 after any cycle in which `rd_en` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_lines | input | 16 | Level-sensitive device requests, asynchronous |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 12 | Byte offset of the write |
| wr_data | input | 16 | Write data |
| rd_en | input | 1 | Register read strobe |
| rd_addr | input | 12 | Byte offset of the read |
| rd_data | output | 16 | Registered read data, valid the cycle after `rd_en` |
| irq_out | output | 1 | Combined interrupt request |

## Verification
The mask write and the vector read can share one cycle, because they have separate address inputs. The bench drives a line that is high but masked. It then writes a mask that enables that line while reading the vector in the same cycle. The read must return 0, which is the pre-write state, while `irq_out` rises at the same edge; a follow-up read must return the line's vector. The same overlap is repeated with the mask read against a mask write, and the returned value must be the old mask.

// File: rtl/lbic_pkg.sv
package lbic_pkg;
  localparam int VEC_OFFSET  = 'h000;
  localparam int MASK_OFFSET = 'h002;
endpackage

// File: rtl/lbic_sync.sv
module lbic_sync #(
  parameter int NLINES = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NLINES-1:0] lines_in,
  output logic [NLINES-1:0] src_q
);
  logic [NLINES-1:0] meta_q;

  for (genvar g = 0; g < NLINES; g++) begin : g_line
    always_ff @(posedge clk) begin
      if (rst) begin
        meta_q[g] <= 1'b0;
        src_q[g]  <= 1'b0;
      end else begin
        meta_q[g] <= lines_in[g];
        src_q[g]  <= meta_q[g];
      end
    end
  end

  logic [1:0] age_q;
  always_ff @(posedge clk) begin
    if (rst) age_q <= '0;
    else if (age_q != 2'd2) age_q <= age_q + 2'd1;
  end

  AST_SYNC_DELAY: assert property (@(posedge clk) disable iff (rst)
    (age_q == 2'd2) |-> (src_q == $past(lines_in, 2))); // R2
endmodule

// File: rtl/lbic_encode.sv
module lbic_encode #(
  parameter int NLINES = 16,
  parameter int DATA_W = 16
) (
  input  logic [NLINES-1:0] pend,
  output logic [DATA_W-1:0] vec
);
  always_comb begin
    vec = '0;
    for (int i = NLINES - 1; i >= 0; i--) begin
      if (pend[i]) vec = DATA_W'((i + 1) << 2);
    end
  end
endmodule

// File: rtl/lbic_regs.sv
module lbic_regs
  import lbic_pkg::*;
#(
  parameter int                NLINES   = 16,
  parameter int                DATA_W   = 16,
  parameter int                ADDR_W   = 12,
  parameter logic [NLINES-1:0] MASK_RST = NLINES'(16'h0010)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  input  logic [DATA_W-1:0] vec,
  output logic [NLINES-1:0] mask_q,
  output logic [DATA_W-1:0] rd_data
);
  localparam logic [ADDR_W-1:0] VEC_A  = ADDR_W'(VEC_OFFSET);
  localparam logic [ADDR_W-1:0] MASK_A = ADDR_W'(MASK_OFFSET);

  logic mask_wr;
  assign mask_wr = wr_en && (wr_addr == MASK_A);

  always_ff @(posedge clk) begin
    if (rst) mask_q <= MASK_RST;
    else if (mask_wr) mask_q <= wr_data[NLINES-1:0];
  end

  logic [DATA_W-1:0] rd_mux;
  always_comb begin
    rd_mux = '0;
    if (rd_addr == VEC_A) rd_mux = vec;
    else if (rd_addr == MASK_A) rd_mux = DATA_W'(mask_q);
  end

  always_ff @(posedge clk) begin
    if (rst || !rd_en) rd_data <= '0;
    else rd_data <= rd_mux;
  end

  AST_RESET_STATE: assert property (@(posedge clk)
    $past(rst) |-> (mask_q == MASK_RST && rd_data == '0)); // R1
  AST_MASK_WRITE: assert property (@(posedge clk) disable iff (rst)
    mask_wr |=> (mask_q == $past(wr_data[NLINES-1:0]))); // R6
  AST_MASK_HOLD: assert property (@(posedge clk) disable iff (rst)
    !mask_wr |=> $stable(mask_q)); // R7
  AST_IDLE_READ: assert property (@(posedge clk) disable iff (rst)
    !rd_en |=> (rd_data == '0)); // R10
endmodule

// File: rtl/lbic_top.sv
module lbic_top
  import lbic_pkg::*;
#(
  parameter int NLINES = 16,
  parameter int DATA_W = 16,
  parameter int ADDR_W = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NLINES-1:0] irq_lines,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data,
  output logic              irq_out
);
  logic [NLINES-1:0] src_q;
  logic [NLINES-1:0] mask_q;
  logic [NLINES-1:0] pend;
  logic [DATA_W-1:0] vec;

  lbic_sync #(.NLINES(NLINES)) u_sync (
    .clk(clk), .rst(rst), .lines_in(irq_lines), .src_q(src_q)
  );

  assign pend    = src_q & mask_q;
  assign irq_out = |pend;

  lbic_encode #(.NLINES(NLINES), .DATA_W(DATA_W)) u_enc (
    .pend(pend), .vec(vec)
  );

  lbic_regs #(.NLINES(NLINES), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst(rst),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_en(rd_en), .rd_addr(rd_addr), .vec(vec),
    .mask_q(mask_q), .rd_data(rd_data)
  );

  AST_IRQ_VS_VEC: assert property (@(posedge clk) disable iff (rst)
    irq_out == (vec != '0)); // R3
  AST_VEC_READ: assert property (@(posedge clk) disable iff (rst)
    (rd_en && rd_addr == ADDR_W'(VEC_OFFSET)) |=> (rd_data == $past(vec))); // R4
endmodule

// File: tb/lbic_top_bench.sv
module lbic_top_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] irq_lines = '0;
  logic        wr_en = 1'b0;
  logic [11:0] wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic        rd_en = 1'b0;
  logic [11:0] rd_addr = '0;
  logic [15:0] rd_data;
  logic        irq_out;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  lbic_top u_lbic_top (
    .clk(clk), .rst(rst), .irq_lines(irq_lines),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data), .irq_out(irq_out)
  );

  // {lines, mask, expected vector, expected irq}
  localparam logic [63:0] VEC_TAB [8] = '{
    64'h0000_FFFF_0000_0000,
    64'h0001_FFFF_0004_0001,
    64'h8000_FFFF_0040_0001,
    64'h8010_FFFF_0014_0001,
    64'h00F0_00C0_001C_0001,
    64'h0F00_00FF_0000_0000,
    64'hFFFF_0400_002C_0001,
    64'h0006_0004_000C_0001
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic do_wr(input logic [11:0] a, input logic [15:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic do_rd(input logic [11:0] a, output logic [15:0] d);
    rd_en = 1'b1; rd_addr = a;
    @(negedge clk);
    rd_en = 1'b0;
    d = rd_data;
  endtask

  task automatic set_lines(input logic [15:0] v);
    irq_lines = v;
    repeat (2) @(negedge clk);
  endtask

  initial begin
    #(20 * 20000);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [15:0] r;
    logic [63:0] row;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk("R1 irq after reset", 32'(irq_out), 32'h0);
    chk("R1 rd_data after reset", 32'(rd_data), 32'h0);
    do_rd(12'h002, r); chk("R1 reset mask", 32'(r), 32'h0010);
    do_rd(12'h000, r); chk("R1 reset vector", 32'(r), 32'h0);
    set_lines(16'h0008);
    chk("R1 masked line 3 stays low", 32'(irq_out), 32'h0);
    set_lines(16'h0010);
    chk("R1 default mask passes line 4", 32'(irq_out), 32'h1);
    set_lines(16'h0000);

    // R2 two-edge latency
    do_wr(12'h002, 16'hFFFF);
    irq_lines = 16'h0008;
    @(negedge clk);
    chk("R2 no change after one edge", 32'(irq_out), 32'h0);
    @(negedge clk);
    chk("R2 rise after two edges", 32'(irq_out), 32'h1);
    irq_lines = 16'h0000;
    @(negedge clk);
    chk("R2 still high after one edge", 32'(irq_out), 32'h1);
    @(negedge clk);
    chk("R2 fall after two edges", 32'(irq_out), 32'h0);
    chk("R10 idle rd_data", 32'(rd_data), 32'h0);

    // R3 R4 R5 R6 table
    for (int k = 0; k < 8; k++) begin
      row = VEC_TAB[k];
      do_wr(12'h002, row[47:32]);
      set_lines(row[63:48]);
      chk("R3 irq level", 32'(irq_out), 32'(row[15:0]));
      do_rd(12'h000, r);
      chk((row[31:16] == 0) ? "R5 zero vector" : "R4 vector", 32'(r), 32'(row[31:16]));
      do_rd(12'h002, r);
      chk("R6 mask readback", 32'(r), 32'(row[47:32]));
    end

    // R6 immediate effect on irq
    set_lines(16'h0100);
    do_wr(12'h002, 16'h0000);
    chk("R6 mask clear drops irq", 32'(irq_out), 32'h0);
    do_wr(12'h002, 16'h0100);
    chk("R6 mask set raises irq", 32'(irq_out), 32'h1);

    // R7 other offsets
    do_wr(12'h004, 16'h0000);
    do_rd(12'h002, r); chk("R7 stray write keeps mask", 32'(r), 32'h0100);
    chk("R7 stray write keeps irq", 32'(irq_out), 32'h1);
    do_wr(12'h003, 16'h0000);
    do_rd(12'h002, r); chk("R7 odd offset keeps mask", 32'(r), 32'h0100);
    do_rd(12'h006, r); chk("R7 stray read zero", 32'(r), 32'h0);

    // R9 source not writable
    do_wr(12'h000, 16'h0000);
    do_rd(12'h000, r); chk("R9 vector unchanged", 32'(r), 32'h0024);
    chk("R9 irq unchanged", 32'(irq_out), 32'h1);

    // R8 same-cycle write and read
    do_wr(12'h002, 16'h0000);
    set_lines(16'h0002);
    wr_en = 1'b1; wr_addr = 12'h002; wr_data = 16'h0002;
    rd_en = 1'b1; rd_addr = 12'h000;
    @(negedge clk);
    wr_en = 1'b0; rd_en = 1'b0;
    chk("R8 read sees pre-write vector", 32'(rd_data), 32'h0);
    chk("R6 irq rises with write", 32'(irq_out), 32'h1);
    do_rd(12'h000, r); chk("R8 follow-up vector", 32'(r), 32'h0008);
    wr_en = 1'b1; wr_addr = 12'h002; wr_data = 16'hFFFF;
    rd_en = 1'b1; rd_addr = 12'h002;
    @(negedge clk);
    wr_en = 1'b0; rd_en = 1'b0;
    chk("R8 read sees old mask", 32'(rd_data), 32'h0002);
    do_rd(12'h002, r); chk("R8 new mask after", 32'(r), 32'hFFFF);

    // R1 reset mid-run
    irq_lines = 16'h0011;
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    chk("R1 irq low after reset", 32'(irq_out), 32'h0);
    repeat (2) @(negedge clk);
    do_rd(12'h000, r); chk("R1 default mask vector", 32'(r), 32'h0014);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule